// File: doc/BRIEF.md
# Streaming Merge-Tree Sorter for Eight Keys

The block takes a batch of eight unsigned keys, one per cycle over a valid/ready input stream, and returns the same eight keys in ascending order over a valid/ready output stream. It sorts by merging runs, not with a fixed network of compare-exchange stages. Each arriving pair of keys is put in order and stored as a run of two in one of four small register FIFOs. Two middle mergers each combine a pair of these runs into a run of four, held in a four-entry register FIFO. A root merger combines the two runs of four into the output sequence.

Each merger looks at the heads of its two source FIFOs without removing them. It forwards the smaller head, and the lower-indexed source wins a tie. Once one source has given up all of its run, the merger empties the other source without comparing. A one-cycle done pulse comes with the handshake of the eighth output. The input stays closed from the eighth accepted key until that pulse, so a new batch starts only when the tree is empty.

Top module: `merge_tree_sorter`

## Requirements
- R1: After reset, out_valid and done are low and in_ready is high.
- R2: Exactly eight keys are accepted per batch. in_ready is low from the cycle after the eighth input handshake until the batch's done pulse, and input stimulus in that window is ignored.
- R3: The eight outputs of a batch are the eight accepted keys in non-decreasing unsigned order, with duplicates kept. No output appears before all eight keys of its batch have been accepted.
- R4: done is high for exactly the cycle in which the eighth output of a batch is handshaken (out_valid and out_ready both high). After that cycle out_valid is low until the next batch has been sorted.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_key stays unchanged on the next cycle.
- R6: In the cycle after done, in_ready is high again and a new batch of eight can begin.
- R7: Gaps in in_valid and stalls on out_ready at any point do not change the sorted result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input key is valid |
| in_ready | output | 1 | Block can accept a key |
| in_key | input | KEY_W | Unsigned key to be sorted |
| out_valid | output | 1 | Output key is valid |
| out_ready | input | 1 | Consumer accepts the output key |
| out_key | output | KEY_W | Next key in ascending order |
| done | output | 1 | Pulses with the eighth output handshake |

## Verification
The hardest case to reach from the ports is a merger whose source has run dry for the current run while the other source still holds entries. This is the only situation in which a merger forwards without comparing. It is also where a tie or an exhausted-side error would show up. The bench reaches it with batches built for the purpose: the first half of a batch holds the largest keys and the second half the smallest; keys alternate between the two extremes; all keys are equal; and one batch has a single tiny key at the end. Each of these batches is run under several rates of input gaps and output back-pressure, including one long output stall while the root still holds part of a run.

// File: rtl/merge_tree_sorter.sv
module merge_tree_sorter #(
  parameter int KEY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [KEY_W-1:0] in_key,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [KEY_W-1:0] out_key,
  output logic             done
);
  localparam int NLEAF = 4;
  localparam int NMID  = 2;
  localparam int LEAF_RUN = 2;
  localparam int MID_RUN  = 4;

  logic [3:0]       in_cnt;
  logic [KEY_W-1:0] held;
  logic [KEY_W-1:0] lf_d [NLEAF][LEAF_RUN];
  logic [NLEAF-1:0] lf_ld;
  logic [1:0]       lf_rd [NLEAF];
  logic [KEY_W-1:0] md_d [NMID][MID_RUN];
  logic [2:0]       md_wr [NMID];
  logic [2:0]       md_rd [NMID];
  logic             out_last;

  logic [NLEAF-1:0] lf_av, lf_ex;
  logic [KEY_W-1:0] lf_hd [NLEAF];
  logic [NMID-1:0]  mfire, mpick_a, md_av, md_ex;
  logic [KEY_W-1:0] md_hd [NMID];
  logic             rfire, rpick_a, rlast;

  wire in_fire  = in_valid && in_ready;
  wire out_free = !out_valid || out_ready;
  wire swap_in  = in_key < held;
  wire [KEY_W-1:0] pair_lo = swap_in ? in_key : held;
  wire [KEY_W-1:0] pair_hi = swap_in ? held : in_key;

  assign in_ready = in_cnt != 4'd8;
  assign done     = out_valid && out_ready && out_last;

  always_comb begin
    for (int i = 0; i < NLEAF; i++) begin
      lf_av[i] = lf_ld[i] && (lf_rd[i] != 2'd2);
      lf_ex[i] = lf_rd[i] == 2'd2;
      lf_hd[i] = lf_d[i][lf_rd[i][0]];
    end
    for (int m = 0; m < NMID; m++) begin
      mfire[m]   = (lf_av[2*m] && (lf_av[2*m+1] || lf_ex[2*m+1])) ||
                   (lf_ex[2*m] && lf_av[2*m+1]);
      mpick_a[m] = lf_av[2*m] && (!lf_av[2*m+1] || lf_hd[2*m] <= lf_hd[2*m+1]);
      md_av[m]   = md_wr[m] != md_rd[m];
      md_ex[m]   = md_rd[m] == 3'd4;
      md_hd[m]   = md_d[m][md_rd[m][1:0]];
    end
    rfire   = out_free && ((md_av[0] && (md_av[1] || md_ex[1])) || (md_ex[0] && md_av[1]));
    rpick_a = md_av[0] && (!md_av[1] || md_hd[0] <= md_hd[1]);
    rlast   = ({1'b0, md_rd[0]} + {1'b0, md_rd[1]}) == 4'd7;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cnt    <= '0;
      held      <= '0;
      lf_ld     <= '0;
      out_valid <= 1'b0;
      out_key   <= '0;
      out_last  <= 1'b0;
      for (int i = 0; i < NLEAF; i++) begin
        lf_rd[i] <= '0;
        for (int j = 0; j < LEAF_RUN; j++) lf_d[i][j] <= '0;
      end
      for (int m = 0; m < NMID; m++) begin
        md_wr[m] <= '0;
        md_rd[m] <= '0;
        for (int j = 0; j < MID_RUN; j++) md_d[m][j] <= '0;
      end
    end else begin
      if (in_fire) begin
        in_cnt <= in_cnt + 4'd1;
        if (!in_cnt[0]) held <= in_key;
        else begin
          lf_d[in_cnt[2:1]][0] <= pair_lo;
          lf_d[in_cnt[2:1]][1] <= pair_hi;
          lf_ld[in_cnt[2:1]]   <= 1'b1;
        end
      end
      for (int m = 0; m < NMID; m++) begin
        if (mfire[m]) begin
          if (mpick_a[m]) lf_rd[2*m]   <= lf_rd[2*m] + 2'd1;
          else            lf_rd[2*m+1] <= lf_rd[2*m+1] + 2'd1;
          md_d[m][md_wr[m][1:0]] <= mpick_a[m] ? lf_hd[2*m] : lf_hd[2*m+1];
          md_wr[m] <= md_wr[m] + 3'd1;
        end
      end
      if (rfire) begin
        out_valid <= 1'b1;
        out_key   <= rpick_a ? md_hd[0] : md_hd[1];
        out_last  <= rlast;
        if (rpick_a) md_rd[0] <= md_rd[0] + 3'd1;
        else         md_rd[1] <= md_rd[1] + 3'd1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (done) begin
        in_cnt   <= '0;
        lf_ld    <= '0;
        out_last <= 1'b0;
        for (int i = 0; i < NLEAF; i++) lf_rd[i] <= '0;
        for (int m = 0; m < NMID; m++) begin
          md_wr[m] <= '0;
          md_rd[m] <= '0;
        end
      end
    end
  end

  assert_leaf_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_cnt[0] |-> !lf_ld[in_cnt[2:1]]);

  generate
    for (genvar g = 0; g < NMID; g++) begin : g_mid_chk
      assert_mid_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mfire[g] |-> md_wr[g] != 3'd4);
    end
  endgenerate

  assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> !out_valid || out_key >= $past(out_key));

  assert_empty_after_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !out_valid);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_key));

  assert_reopen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> in_ready);
endmodule

// File: tb/sim_merge_tree_sorter.sv
module sim_merge_tree_sorter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_key = '0;
  logic       out_ready = 1'b0;
  logic       in_ready, out_valid, done;
  logic [7:0] out_key;

  int checks = 0, errors = 0, cycles = 0;
  int acc = 0, seen = 0, batches = 0;
  int bp_pct = 0, gap_pct = 0;
  bit started = 0, stall_all = 0;
  bit prev_stall = 0;
  logic [7:0] prev_key = '0;
  logic [7:0] batch_q[$];
  logic [7:0] exp_q[$];

  merge_tree_sorter #(.KEY_W(8)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_key(in_key),
    .out_valid(out_valid), .out_ready(out_ready), .out_key(out_key),
    .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  // reference model, evaluated every cycle just after the falling edge
  always @(negedge clk) begin
    #1;
    cycles++;
    if (cycles > WATCHDOG) begin
      chk(0, "watchdog", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (started) begin
      chk(in_ready == (acc < 8), "R2 in_ready", int'(in_ready), int'(acc < 8));
      chk(done == (out_valid && out_ready && seen == 7), "R4 done",
          int'(done), int'(out_valid && out_ready && seen == 7));
      if (prev_stall) begin
        chk(out_valid == 1'b1, "R5 valid held", int'(out_valid), 1);
        chk(out_key == prev_key, "R5 key held", int'(out_key), int'(prev_key));
      end
      if (out_valid) chk(exp_q.size() > 0, "R3 output before batch complete", exp_q.size(), 1);
      if (out_valid && out_ready && exp_q.size() > 0) begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(out_key == e, "R3 R7 sorted key", int'(out_key), int'(e));
        seen++;
        if (seen == 8) begin
          seen = 0;
          acc = 0;
          batches++;
        end
      end
      if (in_valid && in_ready) begin
        batch_q.push_back(in_key);
        acc++;
        if (acc == 8) begin
          batch_q.sort();
          exp_q = batch_q;
          batch_q.delete();
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_key   = out_key;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      out_ready = !stall_all && (($urandom % 100) >= bp_pct);
    end
  end

  task automatic run_batch(input logic [7:0] k[8], input int gap, input int bp);
    int i;
    int target;
    target = batches + 1;
    gap_pct = gap;
    bp_pct = bp;
    i = 0;
    while (i < 8) begin
      @(negedge clk);
      if (($urandom % 100) < gap_pct) begin
        in_valid = 1'b0;
        in_key = 8'hEE;
      end else begin
        in_valid = 1'b1;
        in_key = k[i];
      end
      #1;
      if (in_valid && in_ready) i++;
    end
    @(negedge clk);
    // R2: stimulus during the closed window is ignored
    in_valid = 1'b1;
    in_key = 8'h00;
    while (batches < target) @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [7:0] k[8];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    started = 1;

    for (int b = 0; b < 24; b++) begin
      for (int j = 0; j < 8; j++) begin
        case (b % 8)
          0: k[j] = 8'(j * 3);
          1: k[j] = 8'(200 - j * 7);
          2: k[j] = 8'h55;
          3: k[j] = (j % 2) ? 8'hFF : 8'h00;
          4: k[j] = (j < 4) ? 8'(240 + j) : 8'(j);
          5: k[j] = (j == 7) ? 8'h01 : 8'(100 + (j % 3));
          6: k[j] = 8'($urandom % 4);
          default: k[j] = 8'($urandom);
        endcase
      end
      if (b == 9) begin
        fork
          begin
            stall_all = 1;
            repeat (40) @(negedge clk);
            stall_all = 0;
          end
        join_none
      end
      run_batch(k, (b / 8) * 30, (b % 3) * 40);
    end
    chk(batches == 24, "R6 batch count", batches, 24);
    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule